// File: doc/BRIEF.md
# Sequential Combination Lock

This block guards a door behind a fixed code of several short values. A user keys the values in one at a time. Each entry arrives as a single beat on a valid/ready input stream. The block holds the code as a parameter. A one-hot selector picks the code value that applies to the current step, and a combinational equality check compares it with the entered beat.

A small controller moves one step forward on every matching beat. Any mismatch sends it to a locked-out error state. After the last matching beat it drives the door output high. The open state and the error state both stay put until a synchronous reset.

The state register is one-hot over the entry steps, with one extra top bit that marks open. The error state is all zeros. Because of this encoding, the code selector and the door output are wired straight from state bits and need no decode logic. The input stream applies back-pressure by holding `key_ready` low once the sequence has finished, either open or in error. A beat offered while `key_ready` is low is discarded and has no effect.

Top module: `combo_lock`

## Requirements
- R1: A cycle with `rst` high puts the block in the first entry step on the next edge, whatever `key_valid` and `key_data` are: `code_sel` = 3'b001, `door_open` = 0, `key_ready` = 1.
- R2: In an entry step, a cycle with `key_valid` low leaves `code_sel` and `door_open` unchanged.
- R3: In an entry step, an accepted beat (`key_valid` and `key_ready` both high) whose `key_data` equals the selected code value moves the selector one position up: 001 to 010, and 010 to 100.
- R4: A matching beat in the last step (`code_sel` = 3'b100) opens the door: `door_open` = 1, `code_sel` = 3'b000, `key_ready` = 0.
- R5: An accepted beat that differs from the selected code value, in any step, leads to the error state: `code_sel` = 3'b000, `door_open` = 0, `key_ready` = 0.
- R6: The open state holds until reset. Beats offered there, including correct code values, leave `door_open` = 1 and `code_sel` = 3'b000.
- R7: The error state holds until reset. Beats offered there, including the full correct code, leave `door_open` = 0 and `code_sel` = 3'b000.
- R8: At most one bit of the 4-bit word {`door_open`, `code_sel`} is set at any time. `key_ready` is high exactly when one `code_sel` bit is set.
- R9: With default parameters the code is 3, then 4, then 2, in that order. Step k compares against code slot k, and the slots are packed with slot 0 in the low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | Entry beat offered |
| key_data | input | DATA_W (4) | Entered value |
| key_ready | output | 1 | Block accepts entries (entry steps only) |
| door_open | output | 1 | 1 = door open, 0 = closed |
| code_sel | output | NUM_STEPS (3) | One-hot selector of the code slot being checked; all zero when done |

## Verification
The bench builds the block with its defaults: 4-bit values, three steps, and the code 3, 4, 2. At these values every one of the five states and its exact 4-bit encoding can be observed at the ports. The bench drives a wrong value at each of the three positions, idle gaps between beats, and beats offered in the two terminal states, with correct values among them. It also applies reset from both terminal states, including a reset raised while a beat is being offered.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int LOCK_DATA_W = 4;
  localparam int LOCK_STEPS  = 3;
  // slot 0 in low bits: 3, then 4, then 2
  localparam logic [LOCK_STEPS*LOCK_DATA_W-1:0] LOCK_DEFAULT_CODE = 12'h243;
endpackage

// File: rtl/lock_code_sel.sv
module lock_code_sel #(
  parameter int DATA_W    = 4,
  parameter int NUM_STEPS = 3,
  parameter logic [NUM_STEPS*DATA_W-1:0] CODE = '0
) (
  input  logic [NUM_STEPS-1:0] sel,
  output logic [DATA_W-1:0]    exp_val
);
  logic [DATA_W-1:0] masked [NUM_STEPS];

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_slot
    assign masked[i] = CODE[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}};
  end

  always_comb begin
    exp_val = '0;
    for (int i = 0; i < NUM_STEPS; i++) exp_val = exp_val | masked[i];
  end
endmodule

// File: rtl/lock_cmp.sv
module lock_cmp #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              eq
);
  assign eq = (a == b);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
  parameter int NUM_STEPS = 3,
  localparam int STATE_W  = NUM_STEPS + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               match,
  output logic [STATE_W-1:0] state
);
  localparam logic [STATE_W-1:0] ST_FIRST = STATE_W'(1);
  localparam logic [STATE_W-1:0] ST_ERR   = '0;

  logic [STATE_W-1:0] state_nx;
  logic               in_entry;

  assign in_entry = |state[NUM_STEPS-1:0];

  always_comb begin
    state_nx = state;
    if (in_entry && take) begin
      if (match) state_nx = state << 1;
      else       state_nx = ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FIRST;
    else     state <= state_nx;
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int DATA_W    = LOCK_DATA_W,
  parameter int NUM_STEPS = LOCK_STEPS,
  parameter logic [NUM_STEPS*DATA_W-1:0] CODE = LOCK_DEFAULT_CODE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 key_valid,
  input  logic [DATA_W-1:0]    key_data,
  output logic                 key_ready,
  output logic                 door_open,
  output logic [NUM_STEPS-1:0] code_sel
);
  localparam int STATE_W = NUM_STEPS + 1;

  logic [STATE_W-1:0] state;
  logic [DATA_W-1:0]  exp_val;
  logic               match;

  lock_code_sel #(.DATA_W(DATA_W), .NUM_STEPS(NUM_STEPS), .CODE(CODE)) u_sel (
    .sel(code_sel), .exp_val(exp_val)
  );

  lock_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a(key_data), .b(exp_val), .eq(match)
  );

  lock_ctrl #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .take(key_valid), .match(match), .state(state)
  );

  // outputs are plain state bits
  assign code_sel  = state[NUM_STEPS-1:0];
  assign door_open = state[NUM_STEPS];
  assign key_ready = |code_sel;
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
  parameter int NUM_STEPS = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 key_valid,
  input logic                 key_ready,
  input logic                 door_open,
  input logic [NUM_STEPS-1:0] code_sel
);
  // R1
  a_r1_reset_first: assert property (@(posedge clk)
    rst |=> (code_sel == NUM_STEPS'(1) && !door_open && key_ready));

  // R2
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (key_ready && !key_valid) |=> ($stable(code_sel) && $stable(door_open)));

  // R3, R4, R5
  a_r3_step_or_err: assert property (@(posedge clk) disable iff (rst)
    (key_ready && key_valid) |=>
      ((code_sel == ($past(code_sel) << 1) && !door_open && code_sel != '0) ||
       (door_open && $past(code_sel[NUM_STEPS-1])) ||
       (code_sel == '0 && !door_open)));

  // R6
  a_r6_open_holds: assert property (@(posedge clk) disable iff (rst)
    door_open |=> (door_open && code_sel == '0));

  // R7
  a_r7_err_holds: assert property (@(posedge clk) disable iff (rst)
    (code_sel == '0 && !door_open) |=> (code_sel == '0 && !door_open));

  // R8
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({door_open, code_sel}));

  a_r8_ready_entry: assert property (@(posedge clk) disable iff (rst)
    key_ready == ($countones(code_sel) == 1));
endmodule

bind combo_lock combo_lock_chk #(.NUM_STEPS(NUM_STEPS)) u_chk (
  .clk(clk), .rst(rst), .key_valid(key_valid), .key_ready(key_ready),
  .door_open(door_open), .code_sel(code_sel)
);

// File: tb/combo_lock_bench.sv
`timescale 1ns/1ps
module combo_lock_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       key_valid;
  logic [3:0] key_data;
  logic       key_ready;
  logic       door_open;
  logic [2:0] code_sel;

  int checks = 0;
  int errors = 0;

  // R9: expected code 3, 4, 2
  localparam logic [3:0] C0 = 4'd3, C1 = 4'd4, C2 = 4'd2;
  localparam logic [3:0] ST_S1 = 4'b0001, ST_S2 = 4'b0010, ST_S3 = 4'b0100,
                         ST_OPEN = 4'b1000, ST_ERR = 4'b0000;

  always #2.5 clk = ~clk;

  combo_lock u_combo_lock (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_data(key_data),
    .key_ready(key_ready), .door_open(door_open), .code_sel(code_sel)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // {key_ready, door_open, code_sel}
  function automatic logic [4:0] obs();
    return {key_ready, door_open, code_sel};
  endfunction

  function automatic logic [4:0] want(input logic [3:0] st);
    return {(st[2:0] != 3'b000), st};
  endfunction

  task automatic do_reset(input logic v);
    @(negedge clk);
    rst = 1'b1; key_valid = v; key_data = 4'hF;
    @(negedge clk);
    rst = 1'b0; key_valid = 1'b0;
  endtask

  task automatic send(input logic [3:0] v);
    @(negedge clk);
    key_valid = 1'b1; key_data = v;
    @(negedge clk);
    key_valid = 1'b0; key_data = 4'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    chk("R1 reset state", obs(), want(ST_S1));
  endtask

  task automatic t_open_seq;
    do_reset(1'b0);
    send(C0); chk("R3 step1->2", obs(), want(ST_S2));
    send(C1); chk("R3 step2->3", obs(), want(ST_S3));
    send(C2); chk("R4 R9 open", obs(), want(ST_OPEN));
  endtask

  task automatic t_wrong_at(input int pos);
    do_reset(1'b0);
    if (pos > 0) send(C0);
    if (pos > 1) send(C1);
    send(4'd9);
    chk($sformatf("R5 wrong at step %0d", pos), obs(), want(ST_ERR));
  endtask

  task automatic t_idle_gaps;
    do_reset(1'b0);
    idle(3); chk("R2 idle in step1", obs(), want(ST_S1));
    send(C0); idle(4); chk("R2 idle in step2", obs(), want(ST_S2));
    key_data = C0; idle(2); chk("R2 data without valid", obs(), want(ST_S2));
    send(C1); idle(5); chk("R2 idle in step3", obs(), want(ST_S3));
    send(C2); chk("R4 open after gaps", obs(), want(ST_OPEN));
  endtask

  task automatic t_order;
    do_reset(1'b0);
    send(C1); chk("R9 order: 4 first is wrong", obs(), want(ST_ERR));
    do_reset(1'b0);
    send(C0); send(C2); chk("R9 order: 2 second is wrong", obs(), want(ST_ERR));
  endtask

  task automatic t_open_absorb;
    do_reset(1'b0);
    send(C0); send(C1); send(C2);
    send(4'd7); chk("R6 wrong beat in open", obs(), want(ST_OPEN));
    send(C0); send(C1); send(C2); chk("R6 code again in open", obs(), want(ST_OPEN));
    idle(3); chk("R6 open holds idle", obs(), want(ST_OPEN));
  endtask

  task automatic t_err_absorb;
    do_reset(1'b0);
    send(4'd0);
    send(C0); send(C1); send(C2); chk("R7 code in error", obs(), want(ST_ERR));
    idle(3); chk("R7 error holds idle", obs(), want(ST_ERR));
  endtask

  task automatic t_recover;
    do_reset(1'b0);
    send(C0); send(C1); send(C2);
    do_reset(1'b1); chk("R1 reset from open", obs(), want(ST_S1));
    send(4'd1);
    do_reset(1'b1); chk("R1 reset from error", obs(), want(ST_S1));
    send(C0); send(C1); send(C2); chk("R4 open after recovery", obs(), want(ST_OPEN));
  endtask

  initial begin
    rst = 1'b1; key_valid = 1'b0; key_data = 4'h0;
    idle(2);
    t_reset;
    t_open_seq;
    for (int p = 0; p < 3; p++) t_wrong_at(p);
    t_idle_gaps;
    t_order;
    t_open_absorb;
    t_err_absorb;
    t_recover;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule